// File: doc/BRIEF.md
# Streaming Per-Label Bounding Box Extractor

The block takes a raster-scanned stream of labelled pixels, one per clock, and gathers the bounding box of every labelled region in a single pass. It uses one min/max update unit for all regions. Each region's four extremes live in a small RAM, and the pixel's label is the address. Because every pixel belongs to exactly one region, only one record is read and rewritten per pixel, and that single unit serves any number of labels. The block derives column and row positions itself from the valid, start-of-frame and end-of-line markers.

When the last pixel of a frame has been taken, the block walks through labels 1 upward, one per clock. For each label it presents a presence flag and the four extremes, and it clears that entry so the next frame starts empty. Label 0 is background. The block uses it only to advance the position counters.

Top module: `bbox_label_tracker`

## Requirements
- R1: After reset `rd_valid` and `busy` are 0, and every label reads as not present in the first readout.
- R2: The accepted pixel flagged with `px_sof` sits at column 0, row 0. Each further accepted pixel moves one column right. The pixel after one flagged with `px_eol` is at column 0 of the next row. Cycles with `px_valid` low do not move the position.
- R3: For each label present in a frame, the readout gives the smallest and largest column and row over all accepted pixels carrying that label since the last accepted `px_sof`.
- R4: A readout presents labels 1 to 2^LBL_W-1 in ascending order on consecutive cycles, one per cycle, starting with label 1. Label 0 is never presented and never changes any record.
- R5: Pixels of one label arriving on back-to-back cycles accumulate into the same box exactly as if they were spaced apart.
- R6: A label with no pixel since the last `px_sof` reads out with `rd_seen` = 0 and all four coordinate outputs 0. A present label reads out with `rd_seen` = 1.
- R7: An accepted pixel with `px_eof` high is included in its frame's boxes. On the next cycle `busy` is high and the readout begins.
- R8: While `busy` is high, input pixels are ignored. This includes their `px_sof`, their labels and the position counters.
- R9: Reading out a label clears it, so a label present in one frame and absent in the next reads as not present.
- R10: An accepted `px_sof` arriving in the middle of a frame discards everything gathered for that frame, including a pixel still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | A pixel is presented this cycle |
| px_label | input | LBL_W | Region label of the pixel; 0 is background |
| px_sof | input | 1 | Pixel is the first of a frame |
| px_eol | input | 1 | Pixel is the last of its row |
| px_eof | input | 1 | Pixel is the last of the frame |
| busy | output | 1 | Readout in progress; inputs are ignored |
| rd_valid | output | 1 | Readout entry is valid this cycle |
| rd_label | output | LBL_W | Label of the readout entry |
| rd_seen | output | 1 | Label had at least one pixel in the frame |
| rd_x_lo | output | CRD_W | Smallest column |
| rd_x_hi | output | CRD_W | Largest column |
| rd_y_lo | output | CRD_W | Smallest row |
| rd_y_hi | output | CRD_W | Largest row |

## Verification
On every cycle the assertions check the readout's shape. Labels start at 1, rise by one, never reach 0, and appear only after `busy`. An absent label carries zero coordinates, a present box has its low extremes no larger than its high ones, and an end-of-frame pixel always raises `busy`. Whether the extremes are numerically right shows only in the bench's scenarios: dense label changes, long same-label runs that need forwarding, gaps, the extreme column 255, mid-frame restarts, and pixels injected during readout. The bench compares each readout against boxes it computes from the stimulus.

// File: rtl/bbox_pkg.sv
package bbox_pkg;

  // Readout sequencer state
  typedef enum logic {
    RO_IDLE = 1'b0,
    RO_SCAN = 1'b1
  } ro_state_t;

  // Number of coordinate fields in one record (x_lo, x_hi, y_lo, y_hi)
  localparam int REC_FIELDS = 4;

endpackage

// File: rtl/bbox_coord_gen.sv
module bbox_coord_gen #(
  parameter int CRD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             sof,
  input  logic             eol,
  output logic [CRD_W-1:0] cur_x,
  output logic [CRD_W-1:0] cur_y
);

  logic [CRD_W-1:0] cnt_x;
  logic [CRD_W-1:0] cnt_y;

  // A start-of-frame pixel is at the origin regardless of counter state
  always_comb begin
    cur_x = sof ? '0 : cnt_x;
    cur_y = sof ? '0 : cnt_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_x <= '0;
      cnt_y <= '0;
    end else if (step) begin
      if (eol) begin
        cnt_x <= '0;
        cnt_y <= cur_y + 1'b1;
      end else begin
        cnt_x <= cur_x + 1'b1;
        cnt_y <= cur_y;
      end
    end
  end

endmodule

// File: rtl/bbox_rec_ram.sv
module bbox_rec_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read, read-before-write on a collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bbox_merge.sv
module bbox_merge #(
  parameter int CRD_W = 8
) (
  input  logic [bbox_pkg::REC_FIELDS*CRD_W-1:0] old_rec,
  input  logic                                  fresh,
  input  logic [CRD_W-1:0]                      px_x,
  input  logic [CRD_W-1:0]                      px_y,
  output logic [bbox_pkg::REC_FIELDS*CRD_W-1:0] new_rec
);

  // Field order inside a record, lowest slice first: x_lo, x_hi, y_lo, y_hi
  localparam int NF = bbox_pkg::REC_FIELDS;

  for (genvar f = 0; f < NF; f++) begin : g_field
    localparam bit IS_HI = (f % 2) == 1;
    localparam bit IS_Y  = f >= 2;
    logic [CRD_W-1:0] cur;
    logic [CRD_W-1:0] pos;
    logic             take;
    always_comb begin
      cur  = old_rec[f*CRD_W +: CRD_W];
      pos  = IS_Y ? px_y : px_x;
      take = fresh || (IS_HI ? (pos > cur) : (pos < cur));
      new_rec[f*CRD_W +: CRD_W] = take ? pos : cur;
    end
  end

endmodule

// File: rtl/bbox_readout.sv
module bbox_readout #(
  parameter int LBL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             issue_v,
  output logic [LBL_W-1:0] issue_lbl,
  output logic             ret_v,
  output logic [LBL_W-1:0] ret_lbl
);

  import bbox_pkg::*;

  localparam logic [LBL_W-1:0] LAST_LBL = {LBL_W{1'b1}};

  ro_state_t        state;
  logic [LBL_W-1:0] idx;

  assign issue_v   = (state == RO_SCAN);
  assign issue_lbl = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RO_IDLE;
      idx     <= '0;
      ret_v   <= 1'b0;
      ret_lbl <= '0;
    end else begin
      ret_v   <= issue_v;
      ret_lbl <= idx;
      case (state)
        RO_IDLE: begin
          if (start) begin
            state <= RO_SCAN;
            idx   <= {{(LBL_W-1){1'b0}}, 1'b1};
          end
        end
        RO_SCAN: begin
          if (idx == LAST_LBL) state <= RO_IDLE;
          else                 idx   <= idx + 1'b1;
        end
        default: state <= RO_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bbox_label_tracker.sv
module bbox_label_tracker #(
  parameter int LBL_W = 4,
  parameter int CRD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             px_valid,
  input  logic [LBL_W-1:0] px_label,
  input  logic             px_sof,
  input  logic             px_eol,
  input  logic             px_eof,
  output logic             busy,
  output logic             rd_valid,
  output logic [LBL_W-1:0] rd_label,
  output logic             rd_seen,
  output logic [CRD_W-1:0] rd_x_lo,
  output logic [CRD_W-1:0] rd_x_hi,
  output logic [CRD_W-1:0] rd_y_lo,
  output logic [CRD_W-1:0] rd_y_hi
);

  localparam int NUM_LBL = 1 << LBL_W;
  localparam int REC_W   = bbox_pkg::REC_FIELDS * CRD_W;

  // ---------------- stage 0: accept and position ----------------
  logic             accept;
  logic             restart;
  logic [CRD_W-1:0] cur_x;
  logic [CRD_W-1:0] cur_y;

  logic             s1_eof;
  logic             rd_issue_v;
  logic [LBL_W-1:0] rd_issue_lbl;
  logic             rd_ret_v;
  logic [LBL_W-1:0] rd_ret_lbl;

  always_comb begin
    busy    = s1_eof | rd_issue_v | rd_ret_v;
    accept  = px_valid & ~busy;
    restart = accept & px_sof;
  end

  bbox_coord_gen #(.CRD_W(CRD_W)) u_coord (
    .clk   (clk),
    .rst   (rst),
    .step  (accept),
    .sof   (px_sof),
    .eol   (px_eol),
    .cur_x (cur_x),
    .cur_y (cur_y)
  );

  // ---------------- stage 1 registers ----------------
  logic             s1_upd;
  logic [LBL_W-1:0] s1_lbl;
  logic [CRD_W-1:0] s1_x;
  logic [CRD_W-1:0] s1_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_upd <= 1'b0;
      s1_eof <= 1'b0;
      s1_lbl <= '0;
      s1_x   <= '0;
      s1_y   <= '0;
    end else begin
      s1_upd <= accept & (px_label != '0);
      s1_eof <= accept & px_eof;
      s1_lbl <= px_label;
      s1_x   <= cur_x;
      s1_y   <= cur_y;
    end
  end

  // ---------------- record table ----------------
  logic [LBL_W-1:0] ram_raddr;
  logic [REC_W-1:0] ram_rdata;
  logic             wr_en;
  logic [REC_W-1:0] new_rec;

  assign ram_raddr = rd_issue_v ? rd_issue_lbl : px_label;

  bbox_rec_ram #(.AW(LBL_W), .DW(REC_W)) u_table (
    .clk   (clk),
    .we    (wr_en),
    .waddr (s1_lbl),
    .wdata (new_rec),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  // ---------------- shared update unit with forwarding ----------------
  logic [NUM_LBL-1:0] seen;
  logic               fwd_v;
  logic [LBL_W-1:0]   fwd_lbl;
  logic [REC_W-1:0]   fwd_rec;
  logic [REC_W-1:0]   base_rec;
  logic               fresh;

  always_comb begin
    base_rec = (fwd_v && (fwd_lbl == s1_lbl)) ? fwd_rec : ram_rdata;
    fresh    = ~seen[s1_lbl];
    wr_en    = s1_upd & ~restart;
  end

  bbox_merge #(.CRD_W(CRD_W)) u_merge (
    .old_rec (base_rec),
    .fresh   (fresh),
    .px_x    (s1_x),
    .px_y    (s1_y),
    .new_rec (new_rec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_v   <= 1'b0;
      fwd_lbl <= '0;
      fwd_rec <= '0;
    end else begin
      fwd_v   <= wr_en;
      fwd_lbl <= s1_lbl;
      fwd_rec <= new_rec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
    end else if (restart) begin
      seen <= '0;
    end else begin
      if (wr_en)    seen[s1_lbl]     <= 1'b1;
      if (rd_ret_v) seen[rd_ret_lbl] <= 1'b0;
    end
  end

  // ---------------- readout ----------------
  bbox_readout #(.LBL_W(LBL_W)) u_readout (
    .clk       (clk),
    .rst       (rst),
    .start     (s1_eof),
    .issue_v   (rd_issue_v),
    .issue_lbl (rd_issue_lbl),
    .ret_v     (rd_ret_v),
    .ret_lbl   (rd_ret_lbl)
  );

  logic ret_seen;
  assign ret_seen = seen[rd_ret_lbl];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_label <= '0;
      rd_seen  <= 1'b0;
      rd_x_lo  <= '0;
      rd_x_hi  <= '0;
      rd_y_lo  <= '0;
      rd_y_hi  <= '0;
    end else begin
      rd_valid <= rd_ret_v;
      rd_label <= rd_ret_lbl;
      rd_seen  <= rd_ret_v & ret_seen;
      rd_x_lo  <= ret_seen ? ram_rdata[0*CRD_W +: CRD_W] : '0;
      rd_x_hi  <= ret_seen ? ram_rdata[1*CRD_W +: CRD_W] : '0;
      rd_y_lo  <= ret_seen ? ram_rdata[2*CRD_W +: CRD_W] : '0;
      rd_y_hi  <= ret_seen ? ram_rdata[3*CRD_W +: CRD_W] : '0;
    end
  end

endmodule

// File: rtl/bbox_label_tracker_chk.sv
module bbox_label_tracker_chk #(
  parameter int LBL_W = 4,
  parameter int CRD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             px_valid,
  input logic             px_eof,
  input logic             busy,
  input logic             rd_valid,
  input logic [LBL_W-1:0] rd_label,
  input logic             rd_seen,
  input logic [CRD_W-1:0] rd_x_lo,
  input logic [CRD_W-1:0] rd_x_hi,
  input logic [CRD_W-1:0] rd_y_lo,
  input logic [CRD_W-1:0] rd_y_hi
);

  a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
    rd_valid && $past(rd_valid) |-> rd_label == $past(rd_label) + 1'b1);

  a_r4_first_is_one: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !$past(rd_valid) |-> rd_label == {{(LBL_W-1){1'b0}}, 1'b1});

  a_r4_no_background: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_label != '0);

  a_r6_absent_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_seen |-> (rd_x_lo == '0 && rd_x_hi == '0 && rd_y_lo == '0 && rd_y_hi == '0));

  a_r3_box_ordered: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_seen |-> (rd_x_lo <= rd_x_hi && rd_y_lo <= rd_y_hi));

  a_r7_eof_raises_busy: assert property (@(posedge clk) disable iff (rst)
    px_valid && px_eof && !busy |=> busy);

  a_r8_output_after_busy: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(busy));

endmodule

bind bbox_label_tracker bbox_label_tracker_chk #(.LBL_W(LBL_W), .CRD_W(CRD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .px_valid (px_valid),
  .px_eof   (px_eof),
  .busy     (busy),
  .rd_valid (rd_valid),
  .rd_label (rd_label),
  .rd_seen  (rd_seen),
  .rd_x_lo  (rd_x_lo),
  .rd_x_hi  (rd_x_hi),
  .rd_y_lo  (rd_y_lo),
  .rd_y_hi  (rd_y_hi)
);

// File: tb/bbox_label_tracker_bench.sv
module bbox_label_tracker_bench;

  localparam int LBL_W = 4;
  localparam int CRD_W = 8;
  localparam int NL    = 1 << LBL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             px_valid = 1'b0;
  logic [LBL_W-1:0] px_label = '0;
  logic             px_sof = 1'b0;
  logic             px_eol = 1'b0;
  logic             px_eof = 1'b0;
  logic             busy;
  logic             rd_valid;
  logic [LBL_W-1:0] rd_label;
  logic             rd_seen;
  logic [CRD_W-1:0] rd_x_lo, rd_x_hi, rd_y_lo, rd_y_hi;

  always #2 clk = ~clk;

  bbox_label_tracker #(.LBL_W(LBL_W), .CRD_W(CRD_W)) u_bbox_label_tracker (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_label(px_label),
    .px_sof(px_sof), .px_eol(px_eol), .px_eof(px_eof), .busy(busy),
    .rd_valid(rd_valid), .rd_label(rd_label), .rd_seen(rd_seen),
    .rd_x_lo(rd_x_lo), .rd_x_hi(rd_x_hi), .rd_y_lo(rd_y_lo), .rd_y_hi(rd_y_hi)
  );

  int checks = 0;
  int failures = 0;

  // Expected boxes, computed from the stimulus
  int m_seen [NL];
  int m_xl [NL], m_xh [NL], m_yl [NL], m_yh [NL];
  int mx = 0, my = 0;

  // Captured readout
  int g_seen [NL];
  int g_xl [NL], g_xh [NL], g_yl [NL], g_yh [NL];
  int got_cnt = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      check(int'(rd_label) == got_cnt + 1, "R4", "readout label order", int'(rd_label), got_cnt + 1);
      g_seen[rd_label] = int'(rd_seen);
      g_xl[rd_label] = int'(rd_x_lo);
      g_xh[rd_label] = int'(rd_x_hi);
      g_yl[rd_label] = int'(rd_y_lo);
      g_yh[rd_label] = int'(rd_y_hi);
      got_cnt++;
    end
  end

  function automatic int lbl_of(input int kind, input int x, input int y, input int w, input int h);
    case (kind)
      1: return ((x / 4) + 3 * (y / 3)) % 16;
      2: return ((x + y) % 2 == 1) ? 9 : 10;
      3: return (x == 0 && y == 0) ? 1 : ((x == w-1 && y == h-1) ? 15 : ((x == w/2 && y == 0) ? 8 : 0));
      4: return 5;
      5: return (x < 3) ? 6 : 0;
      6: return (y % 2 == 1) ? 12 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic model_px(input int l, input bit s, input bit e);
    if (s) begin
      mx = 0; my = 0;
      for (int i = 0; i < NL; i++) m_seen[i] = 0;
    end
    if (l != 0) begin
      if (m_seen[l] == 0) begin
        m_seen[l] = 1; m_xl[l] = mx; m_xh[l] = mx; m_yl[l] = my; m_yh[l] = my;
      end else begin
        if (mx < m_xl[l]) m_xl[l] = mx;
        if (mx > m_xh[l]) m_xh[l] = mx;
        if (my < m_yl[l]) m_yl[l] = my;
        if (my > m_yh[l]) m_yh[l] = my;
      end
    end
    if (e) begin mx = 0; my = my + 1; end
    else mx = mx + 1;
  endtask

  task automatic drive(input bit v, input int l, input bit s, input bit e, input bit f);
    @(negedge clk);
    px_valid = v; px_label = l[LBL_W-1:0]; px_sof = s; px_eol = e; px_eof = f;
  endtask

  // Sends a whole frame; the inputs are left on the last pixel
  task automatic frame(input int w, input int h, input int kind, input int gap, input bit with_eof);
    got_cnt = 0;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int l;
        bit s, e, f;
        l = lbl_of(kind, x, y, w, h);
        s = (x == 0 && y == 0);
        e = (x == w - 1);
        f = with_eof && e && (y == h - 1);
        if (gap != 0 && ((x * 7 + y) % gap == 0)) drive(1'b0, 3, 1'b0, 1'b0, 1'b0);
        drive(1'b1, l, s, e, f);
        model_px(l, s, e);
      end
    end
  endtask

  task automatic wait_readout(input string tag);
    int n;
    n = 0;
    while ((got_cnt < NL - 1 || busy) && n < 200) begin
      @(posedge clk);
      n++;
    end
    check(n < 200, "R7", {tag, " readout completed"}, got_cnt, NL - 1);
  endtask

  task automatic compare_all(input string tag, input string req);
    for (int l = 1; l < NL; l++) begin
      if (m_seen[l] != 0) begin
        check(g_seen[l] == 1 && g_xl[l] == m_xl[l] && g_xh[l] == m_xh[l] &&
              g_yl[l] == m_yl[l] && g_yh[l] == m_yh[l], req,
              $sformatf("%s label %0d box x %0d..%0d y %0d..%0d", tag, l, g_xl[l], g_xh[l], g_yl[l], g_yh[l]),
              g_seen[l] * 1000 + g_xl[l], 1000 + m_xl[l]);
      end else begin
        check(g_seen[l] == 0 && g_xl[l] == 0 && g_xh[l] == 0 && g_yl[l] == 0 && g_yh[l] == 0,
              "R6", $sformatf("%s label %0d absent", tag, l), g_seen[l] * 1000 + g_xh[l], 0);
      end
    end
  endtask

  task automatic end_frame(input string tag, input string req);
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    check(busy == 1'b1, "R7", {tag, " busy after end of frame"}, int'(busy), 1);
    wait_readout(tag);
    compare_all(tag, req);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_seen[i] = 0; g_seen[i] = 0;
      g_xl[i] = 0; g_xh[i] = 0; g_yl[i] = 0; g_yh[i] = 0;
      m_xl[i] = 0; m_xh[i] = 0; m_yl[i] = 0; m_yh[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    // R1: background-only frame after reset: everything absent
    frame(3, 2, 0, 0, 1'b1);
    end_frame("bg", "R1");

    // R2, R3: mixed labels with bubbles
    frame(20, 12, 1, 5, 1'b1);
    end_frame("mixed", "R3");

    // R3: label changes every pixel, no bubbles
    frame(9, 7, 2, 0, 1'b1);
    end_frame("checker", "R3");

    // R2: extreme column 255 and first/last pixel included (R7)
    frame(256, 2, 3, 0, 1'b1);
    end_frame("corner", "R2");

    // R5: long back-to-back runs of one label
    frame(10, 5, 6, 0, 1'b1);
    end_frame("runs", "R5");

    // R9: labels 9/10 existed earlier; frame without them reads them absent
    frame(4, 4, 5, 3, 1'b1);
    end_frame("clear", "R9");

    // R10: partial frame of label 5 abandoned by a new start of frame
    frame(8, 1, 4, 0, 1'b0);
    frame(5, 3, 5, 0, 1'b1);
    end_frame("restart", "R10");

    // R8: pixels with start-of-frame and label 7 during readout are ignored
    frame(6, 3, 2, 0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 7, 1'b1, 1'b1, 1'b0);
      check(busy == 1'b1, "R8", "busy while injecting", int'(busy), 1);
    end
    drive(1'b0, 0, 1'b0, 1'b0, 1'b0);
    wait_readout("inject");
    compare_all("inject", "R8");

    // R8: a following frame is unaffected by the injected pixels
    frame(3, 3, 5, 0, 1'b1);
    end_frame("after", "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule